// File: doc/BRIEF.md
# Frame Readout DMA Sequencer

This block sits between a video capture path, a shared frame memory and a byte-wide host link. In normal operation the capture side owns the memory. The write address comes from the capture write counter, and every capture write strobe reaches the memory write enable.

When the host raises a read request, the block keeps capture running until a whole interlaced frame is in memory. It recognises that point at the vertical sync edge that closes an odd field. It then makes the following changes:

- It blocks writes.
- It turns the capture source's bus drivers off.
- It turns the memory's data outputs on.
- It switches the address bus to an internal read counter loaded with the start address.
- It raises an acknowledge to the requester.

Pixels are then fetched one row after another. Each fetch holds its address for a programmable number of cycles, which sets a slow pixel rate. Each 16-bit word is handed downstream as two bytes over a ready/valid handshake.

After the stop address has been sent, the block drops the acknowledge and hands the bus back to capture. Writes start again at the next field start.

Top module: `frame_readout_seq`

## Requirements
- R1: While no readout is in progress, `mem_we` equals `cap_wr_en`, `mem_addr` equals `cap_addr`, `cap_oe` is 1, and `mem_oe`, `rd_sel` and `rd_ack` are 0.
- R2: A pending request starts readout only at a rising edge of `vref` that ends an odd field. Field parity is sampled from `field_odd` on each falling edge of `vref`, with 1 meaning odd. A rising edge that ends an even field is ignored.
- R3: In the cycle after that starting edge, `rd_sel`=1, `mem_we`=0, `cap_oe`=0, `mem_oe`=1 and `mem_addr`=`start_addr`. `rd_ack` rises one cycle later and stays high until the last byte is accepted.
- R4: Each pixel address is held for PACE_CYCLES cycles after its fetch begins, before its first byte is offered.
- R5: Each word is sent as two bytes, bits [7:0] first and then bits [15:8]. The high byte is offered in the cycle after the low byte is accepted. A byte stays valid and unchanged until `out_ready` is high.
- R6: Read addresses go from `start_addr` to `stop_addr` inclusive, rising by one and wrapping modulo 2^ADDR_W. The counter moves only after both bytes of a word are accepted. Equal start and stop give exactly one pixel.
- R7: In the cycle after the final byte is accepted, `rd_ack`, `rd_sel` and `mem_oe` are 0 and `cap_oe` is 1. `mem_we` stays 0 until the next rising edge of `vref`, and from then on it follows `cap_wr_en`.
- R8: After reset the block is in capture mode with `out_valid`, `rd_ack` and `rd_sel` at 0 and the latched field parity even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Host request to read one frame |
| vref | input | 1 | Vertical sync, high at the start of each field |
| field_odd | input | 1 | Field parity, sampled on the falling edge of vref |
| cap_wr_en | input | 1 | Write strobe from the capture path |
| cap_addr | input | ADDR_W | Address from the capture write counter |
| start_addr | input | ADDR_W | First read address |
| stop_addr | input | ADDR_W | Last read address |
| mem_rdata | input | PIX_W | Word driven by the memory |
| out_ready | input | 1 | Downstream accepts the current byte |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_we | output | 1 | Memory write enable |
| mem_oe | output | 1 | Memory output enable |
| cap_oe | output | 1 | Capture source bus drive enable (0 = high impedance) |
| rd_sel | output | 1 | Address source select (1 = read counter) |
| rd_ack | output | 1 | Frame ready for transfer |
| out_data | output | PIX_W/2 | Byte to downstream |
| out_valid | output | 1 | out_data is valid |

## Verification
Four readouts drive the main function, each with its own address range and stall depth:

- A short in-range run.
- A single-pixel run, where start equals stop.
- A run that wraps past the top address.
- A run from address zero with long stalls.

Together they separate a correct inclusive end test from an off-by-one, a wrapping counter from a saturating one, and a held byte from one that moves during back-pressure. Before every readout the field sequence is even, then odd, then the next field start, so a block that starts at any sync edge is told apart from one that waits for the odd field to close. A final run with no request pending shows that sync edges alone start nothing.

// File: rtl/frame_readout_seq.sv
module frame_readout_seq #(
  parameter int ADDR_W      = 10,
  parameter int PIX_W       = 16,
  parameter int PACE_CYCLES = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              vref,
  input  logic              field_odd,
  input  logic              cap_wr_en,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] stop_addr,
  input  logic [PIX_W-1:0]  mem_rdata,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_oe,
  output logic              cap_oe,
  output logic              rd_sel,
  output logic              rd_ack,
  output logic [PIX_W/2-1:0] out_data,
  output logic              out_valid
);

  localparam int BYTE_W = PIX_W / 2;
  localparam int CNT_W  = $clog2(PACE_CYCLES + 1);
  localparam logic [CNT_W-1:0] PACE_LAST = CNT_W'(PACE_CYCLES - 1);

  typedef enum logic [2:0] {
    S_CAP, S_ARM, S_SETUP, S_FETCH, S_LO, S_HI, S_RESYNC
  } st_t;

  st_t st, st_nx;
  logic              vref_q, odd_q;
  logic [ADDR_W-1:0] rd_addr;
  logic [CNT_W-1:0]  pace;
  logic [PIX_W-1:0]  word;

  wire vref_rise  = vref & ~vref_q;
  wire frame_done = vref_rise & odd_q;
  wire last_pix   = rd_addr == stop_addr;
  wire fetch_end  = (st == S_FETCH) && (pace == PACE_LAST);

  always_comb begin
    st_nx = st;
    case (st)
      S_CAP:    if (rd_req) st_nx = S_ARM;
      S_ARM:    if (frame_done) st_nx = S_SETUP;
      S_SETUP:  st_nx = S_FETCH;
      S_FETCH:  if (fetch_end) st_nx = S_LO;
      S_LO:     if (out_ready) st_nx = S_HI;
      S_HI:     if (out_ready) st_nx = last_pix ? S_RESYNC : S_FETCH;
      S_RESYNC: if (vref_rise) st_nx = S_CAP;
      default:  st_nx = S_CAP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_CAP;
      vref_q  <= 1'b0;
      odd_q   <= 1'b0;
      rd_addr <= '0;
      pace    <= '0;
      word    <= '0;
    end else begin
      st     <= st_nx;
      vref_q <= vref;
      if (!vref && vref_q) odd_q <= field_odd;
      if (st == S_FETCH) pace <= pace + 1'b1;
      else               pace <= '0;
      if (fetch_end) word <= mem_rdata;
      if (st == S_ARM && frame_done)
        rd_addr <= start_addr;
      else if (st == S_HI && out_ready && !last_pix)
        rd_addr <= rd_addr + 1'b1;
    end
  end

  assign rd_sel    = (st == S_SETUP) || (st == S_FETCH) || (st == S_LO) || (st == S_HI);
  assign rd_ack    = (st == S_FETCH) || (st == S_LO) || (st == S_HI);
  assign mem_we    = cap_wr_en && ((st == S_CAP) || (st == S_ARM));
  assign mem_oe    = rd_sel;
  assign cap_oe    = !rd_sel;
  assign mem_addr  = rd_sel ? rd_addr : cap_addr;
  assign out_valid = (st == S_LO) || (st == S_HI);
  assign out_data  = (st == S_HI) ? word[PIX_W-1:BYTE_W] : word[BYTE_W-1:0];

  a_r2_start_on_odd_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_sel) |-> $past(vref && !vref_q && odd_q));

  a_r3_ack_after_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ack) |-> rd_sel && $past(rd_sel) && !mem_we);

  a_r5_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI) && out_ready && !last_pix |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  a_r7_no_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_ack) |-> !mem_we && cap_oe && !mem_oe);

endmodule

// File: tb/frame_readout_seq_test.sv
module frame_readout_seq_test;
  localparam int AW   = 10;
  localparam int PW   = 16;
  localparam int PACE = 4;

  localparam logic [23:0] VEC [4] = '{
    {10'd5,    10'd8,   4'd0},
    {10'd100,  10'd100, 4'd2},
    {10'd1022, 10'd1,   4'd1},
    {10'd0,    10'd3,   4'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req = 1'b0, vref = 1'b0, field_odd = 1'b0, cap_wr_en = 1'b0, out_ready = 1'b0;
  logic [AW-1:0] cap_addr = '0, start_addr = '0, stop_addr = '0;
  logic [PW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_we, mem_oe, cap_oe, rd_sel, rd_ack, out_valid;
  logic [PW/2-1:0] out_data;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] pix(input logic [9:0] a);
    return {~a[7:0] ^ {6'b0, a[9:8]}, a[7:0] + 8'h21};
  endfunction

  assign mem_rdata = mem_oe ? pix(mem_addr) : 16'hDEAD;

  frame_readout_seq #(.ADDR_W(AW), .PIX_W(PW), .PACE_CYCLES(PACE)) uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .vref(vref), .field_odd(field_odd),
    .cap_wr_en(cap_wr_en), .cap_addr(cap_addr), .start_addr(start_addr),
    .stop_addr(stop_addr), .mem_rdata(mem_rdata), .out_ready(out_ready),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_oe(mem_oe), .cap_oe(cap_oe),
    .rd_sel(rd_sel), .rd_ack(rd_ack), .out_data(out_data), .out_valid(out_valid));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!out_valid && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic get_byte(input string tag, input logic [7:0] exp, input int stall);
    for (int s = 0; s < stall; s++) begin
      chk({tag, " held"}, 32'(out_data), 32'(exp));
      @(negedge clk);
    end
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk(tag, 32'(out_data), 32'(exp));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic pulse(input logic odd);
    field_odd = odd;
    vref = 1'b1;
    repeat (2) @(negedge clk);
    vref = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input logic [9:0] sa, input logic [9:0] ea, input int stall);
    int n;
    int cnt;
    logic [9:0] a;
    @(negedge clk);
    start_addr = sa; stop_addr = ea; cap_addr = 10'h155; cap_wr_en = 1'b1;
    rd_req = 1'b1; field_odd = 1'b0;
    @(negedge clk);
    chk("R1 we follows strobe", 32'(mem_we), 32'd1);
    chk("R1 capture address", 32'(mem_addr), 32'h155);
    chk("R1 capture drives bus", 32'(cap_oe), 32'd1);
    cap_wr_en = 1'b0;
    @(negedge clk);
    chk("R1 we low with strobe", 32'(mem_we), 32'd0);
    cap_wr_en = 1'b1;
    pulse(1'b0);
    chk("R2 no start after even pulse", 32'(rd_sel), 32'd0);
    pulse(1'b1);
    chk("R2 no start on edge closing even field", 32'(rd_sel), 32'd0);
    chk("R1 still writing while armed", 32'(mem_we), 32'd1);
    vref = 1'b1; field_odd = 1'b0;
    @(negedge clk);
    chk("R3 select read counter", 32'(rd_sel), 32'd1);
    chk("R3 writes blocked", 32'(mem_we), 32'd0);
    chk("R3 capture tristated", 32'(cap_oe), 32'd0);
    chk("R3 memory drives", 32'(mem_oe), 32'd1);
    chk("R3 start address", 32'(mem_addr), 32'(sa));
    chk("R3 ack not yet", 32'(rd_ack), 32'd0);
    vref = 1'b0; rd_req = 1'b0;
    @(negedge clk);
    chk("R3 ack raised", 32'(rd_ack), 32'd1);
    cnt = 32'((ea - sa) & 10'h3FF) + 1;
    for (int i = 0; i < cnt; i++) begin
      a = 10'(sa + 10'(i));
      wait_valid(n);
      chk("R4 fetch pacing", 32'(n), 32'(PACE));
      chk("R6 read address", 32'(mem_addr), 32'(a));
      chk("R3 ack held", 32'(rd_ack), 32'd1);
      get_byte("R5 low byte", pix(a)[7:0], stall);
      wait_valid(n);
      chk("R5 high byte follows at once", 32'(n), 32'd0);
      get_byte("R5 high byte", pix(a)[15:8], stall);
    end
    chk("R7 ack dropped", 32'(rd_ack), 32'd0);
    chk("R7 read select dropped", 32'(rd_sel), 32'd0);
    chk("R7 capture drives again", 32'(cap_oe), 32'd1);
    chk("R7 memory released", 32'(mem_oe), 32'd0);
    chk("R6 no extra byte", 32'(out_valid), 32'd0);
    repeat (3) @(negedge clk);
    chk("R7 writes held off", 32'(mem_we), 32'd0);
    vref = 1'b1;
    @(negedge clk);
    chk("R7 writes resume at field start", 32'(mem_we), 32'd1);
    vref = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", 32'(out_valid), 32'd0);
    chk("R8 reset ack", 32'(rd_ack), 32'd0);
    chk("R8 reset select", 32'(rd_sel), 32'd0);
    chk("R8 reset capture drive", 32'(cap_oe), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    pulse(1'b0);
    chk("R8 parity starts even", 32'(rd_sel), 32'd0);
    for (int v = 0; v < 4; v++)
      run_frame(VEC[v][23:14], VEC[v][13:4], int'(VEC[v][3:0]));
    cap_wr_en = 1'b1;
    pulse(1'b1);
    pulse(1'b0);
    chk("R2 no start without request", 32'(rd_sel), 32'd0);
    chk("R1 capture unaffected", 32'(mem_we), 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R4 actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule